// File: doc/BRIEF.md
# Shared Memory Port Cycle Scheduler

A processor with a single memory port must share it between three users: instruction fetch, periodic video refresh DMA and data loads/stores from the execute stage. This block picks the user of the port for every clock. Memory cycles are pipelined: the address, the write strobe and the cycle kind for the next cycle are registered during the current one. Completion of the cycle in progress is signalled by a ready input.

The block also produces one pipeline enable that drives every fetch, decode and execute register enable. The enable drops when memory is not ready and when the port is taken by DMA. It also drops in the fetch cycle during which a load/store is waiting in execute. A load or store therefore costs one extra cycle with no wait states. The refresh request comes from an internal free-running timer. It stays pending until a DMA cycle completes.

Top module: `mem_cycle_sched`

## Requirements
- R1: After reset the cycle in progress is a fetch (kind 2'b00) at address 0 with the write strobe low. The timer starts at zero and no DMA is pending.
- R2: `cyc_kind` encodes the cycle in progress as 2'b00 fetch, 2'b01 DMA or 2'b10 load/store. The value 2'b11 never appears.
- R3: While `mem_rdy` is low, `pipe_en` is low.
- R4: When `mem_rdy` is low, `mem_addr`, `mem_we` and `cyc_kind` keep their values on the next clock.
- R5: The timer raises a DMA request once every DMA_PERIOD clocks, in the clock where it reads DMA_PERIOD-1. With ready always high, exactly one DMA cycle runs per DMA_PERIOD clocks.
- R6: A DMA request stays pending until a DMA cycle completes with `mem_rdy` high. A pending request is served on the first cycle that follows a ready completion.
- R7: When a cycle completes with ready, the next cycle is chosen in this order: DMA if one is pending, then load/store if `ls_req` is high and the completing cycle is not a load/store, then fetch.
- R8: A fetch cycle drives `fetch_addr`, a DMA cycle drives `dma_addr`, and a load/store cycle drives `ls_addr`. Each address is the value sampled at the clock that chose the cycle. `mem_we` equals the sampled `ls_we` on a load/store cycle and is low otherwise.
- R9: `pipe_en` is high when a load/store cycle completes with ready. It is also high when a fetch cycle completes with ready and `ls_req` is low. It is low during DMA cycles.
- R10: One load/store request gets one load/store cycle: a completing load/store cycle is never followed directly by another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdy | input | 1 | Cycle in progress completes this clock |
| ls_req | input | 1 | Execute stage holds a load or store |
| ls_we | input | 1 | The held access is a store |
| fetch_addr | input | AW | Next instruction address |
| dma_addr | input | AW | Next refresh address |
| ls_addr | input | AW | Load/store data address |
| mem_addr | output | AW | Address of the cycle in progress |
| mem_we | output | 1 | Write strobe of the cycle in progress |
| cyc_kind | output | 2 | Kind of the cycle in progress |
| pipe_en | output | 1 | Global pipeline register enable |

## Verification
The bench builds the block with AW=12 and DMA_PERIOD=4. The short refresh period puts a DMA request close to almost every load/store and wait state. Collisions of a pending DMA with a waiting load, and a refresh tick that lands while a DMA cycle completes, therefore happen many times in a short run. The narrow address keeps every driven address distinct within a scenario, so a cycle that takes the wrong source is visible at once.

// File: rtl/mem_cycle_sched.sv
module mem_cycle_sched #(
  parameter int AW = 16,
  parameter int DMA_PERIOD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_rdy,
  input  logic          ls_req,
  input  logic          ls_we,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] dma_addr,
  input  logic [AW-1:0] ls_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [1:0]    cyc_kind,
  output logic          pipe_en
);
  localparam int CW = (DMA_PERIOD > 2) ? $clog2(DMA_PERIOD) : 1;
  localparam logic [CW-1:0] TMR_LAST = CW'(DMA_PERIOD - 1);
  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_DMA   = 2'b01;
  localparam logic [1:0] K_LS    = 2'b10;

  logic [CW-1:0] tmr;
  logic          dma_pend;
  logic          tick, dma_want, ls_want;
  logic [1:0]    kind_nx;
  logic [AW-1:0] addr_nx;

  assign tick     = (tmr == TMR_LAST);
  assign dma_want = tick | (dma_pend & ~(cyc_kind == K_DMA & mem_rdy));
  assign ls_want  = ls_req & (cyc_kind != K_LS);
  assign pipe_en  = mem_rdy & ((cyc_kind == K_LS) | ((cyc_kind == K_FETCH) & ~ls_req));

  always_comb begin
    if (dma_want) begin
      kind_nx = K_DMA;
      addr_nx = dma_addr;
    end else if (ls_want) begin
      kind_nx = K_LS;
      addr_nx = ls_addr;
    end else begin
      kind_nx = K_FETCH;
      addr_nx = fetch_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      dma_pend <= 1'b0;
      cyc_kind <= K_FETCH;
      mem_addr <= '0;
      mem_we   <= 1'b0;
    end else begin
      tmr      <= tick ? '0 : tmr + 1'b1;
      dma_pend <= dma_want;
      if (mem_rdy) begin
        cyc_kind <= kind_nx;
        mem_addr <= addr_nx;
        mem_we   <= (kind_nx == K_LS) & ls_we;
      end
    end
  end

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rdy |=> $stable(mem_addr) && $stable(mem_we) && $stable(cyc_kind)); // R4
  AST_LEGAL_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_kind != 2'b11); // R2
  AST_DMA_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_pend && mem_rdy && cyc_kind != K_DMA) |=> cyc_kind == K_DMA); // R6
  AST_LS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == K_LS && mem_rdy) |=> cyc_kind != K_LS); // R10
  AST_WE_ONLY_LS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> cyc_kind == K_LS); // R8
  AST_LS_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rdy && ls_req && !dma_want && cyc_kind != K_LS)
      |=> (cyc_kind == K_LS && mem_addr == $past(ls_addr))); // R7
  AST_DMA_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == K_DMA) |-> !pipe_en); // R9
endmodule

// File: tb/tb_mem_cycle_sched.sv
module tb_mem_cycle_sched;
  localparam int AW = 12;
  localparam int P  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_rdy = 1'b1, ls_req = 1'b0, ls_we = 1'b0;
  logic [AW-1:0] fetch_addr = '0, dma_addr = '0, ls_addr = '0;
  logic [AW-1:0] mem_addr;
  logic mem_we, pipe_en;
  logic [1:0] cyc_kind;
  int nchk = 0, nerr = 0, ncyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mem_cycle_sched #(.AW(AW), .DMA_PERIOD(P)) dut (
    .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .ls_req(ls_req), .ls_we(ls_we),
    .fetch_addr(fetch_addr), .dma_addr(dma_addr), .ls_addr(ls_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .cyc_kind(cyc_kind), .pipe_en(pipe_en));

  // Reference model built from the requirements.
  int m_tmr;
  bit m_pend, m_we;
  logic [1:0] m_kind;
  logic [AW-1:0] m_addr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tmr <= 0; m_pend <= 0; m_kind <= 2'b00; m_addr <= '0; m_we <= 0;       // R1
    end else begin
      bit tk, want;
      tk = (m_tmr == P - 1);                                                   // R5
      want = tk || (m_pend && !(m_kind == 2'b01 && mem_rdy));                  // R6
      m_tmr <= tk ? 0 : m_tmr + 1;
      m_pend <= want;
      if (mem_rdy) begin                                                       // R4
        if (want) begin m_kind <= 2'b01; m_addr <= dma_addr; m_we <= 0; end    // R7 R8
        else if (ls_req && m_kind != 2'b10) begin
          m_kind <= 2'b10; m_addr <= ls_addr; m_we <= ls_we;                   // R10
        end else begin m_kind <= 2'b00; m_addr <= fetch_addr; m_we <= 0; end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic compare(string sc);
    logic exp_en;
    exp_en = mem_rdy && (m_kind == 2'b10 || (m_kind == 2'b00 && !ls_req));
    chk({sc, " R2 R7 kind"}, 32'(cyc_kind), 32'(m_kind));
    chk({sc, " R8 addr"}, 32'(mem_addr), 32'(m_addr));
    chk({sc, " R8 we"}, 32'(mem_we), 32'(m_we));
    chk({sc, " R3 R9 pipe_en"}, 32'(pipe_en), 32'(exp_en));
  endtask

  task automatic cycle(string sc, logic rdy, logic lr, logic lw);
    @(negedge clk);
    ncyc++;
    mem_rdy = rdy; ls_req = lr; ls_we = lw;
    fetch_addr = AW'(12'h100 + ncyc);
    dma_addr   = AW'(12'h800 + ncyc);
    ls_addr    = AW'(12'h400 + ncyc);
    #1;
    compare(sc);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 kind after reset", 32'(cyc_kind), 0);
    chk("R1 addr after reset", 32'(mem_addr), 0);
    chk("R1 we after reset", 32'(mem_we), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_fetch_stream;
    int ndma = 0;
    for (int i = 0; i < 8 * P; i++) begin
      cycle("fetch_stream", 1'b1, 1'b0, 1'b0);
      if (cyc_kind == 2'b01) ndma++;
    end
    chk("R5 DMA cycles per window", 32'(ndma), 32'(8));
  endtask

  task automatic t_wait_states;
    for (int i = 0; i < 20; i++)
      cycle("wait_states R4", (i % 3) != 1, 1'b0, 1'b0);
  endtask

  task automatic do_ls(string sc, logic lw, int rdy_gap);
    int guard = 0;
    bit done = 0;
    while (!done && guard < 40) begin
      logic r;
      r = (rdy_gap == 0) || ((guard % rdy_gap) != 0);
      cycle(sc, r, 1'b1, lw);
      if (cyc_kind == 2'b10 && pipe_en) done = 1;
      guard++;
    end
    chk({sc, " R10 load/store retired"}, 32'(done), 1);
    cycle(sc, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_loads;
    do_ls("load_nowait", 1'b0, 0);
    do_ls("store_nowait", 1'b1, 0);
    for (int i = 0; i < 2 * P; i++) begin
      cycle("ls_phase", 1'b1, 1'b0, 1'b0);
      do_ls("ls_vs_dma R7", i[0], 0);
    end
  endtask

  task automatic t_slow_ls;
    do_ls("load_wait R4", 1'b0, 2);
    do_ls("store_wait R6", 1'b1, 3);
  endtask

  task automatic t_dma_blocked;
    for (int i = 0; i < 3 * P; i++) cycle("dma_blocked R6", 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 2 * P; i++) cycle("dma_release R6", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_fetch_stream;
    t_wait_states;
    t_loads;
    t_slow_ls;
    t_dma_blocked;
    t_reset;
    t_loads;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule